// File: doc/BRIEF.md
# Single-channel memory-to-memory DMA transfer controller

This block is one channel of a DMA engine that copies memory to memory. Software programs it through a small 32-bit register window with a source address, a destination address, a unit count, a request-type field and a control/status word. Once the channel is enabled, and the controller-wide enable input is high, it copies one unit at a time. Each unit is a read from the source address and then a write of the same data to the destination address. Both go over a request/acknowledge master port that is wide enough to carry the largest unit in one beat.

After each unit the channel decrements the count. It also advances each address whose step bit is set, by the unit size in bytes. When the count reaches zero a sticky completion flag is set, and an interrupt is raised if the interrupt enable is set. Software drops the interrupt by writing zero to the completion flag. Before any unit starts, both addresses are checked against the unit size. A misaligned address, or an undefined size code, sets a sticky error flag and the channel moves nothing.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Register byte offsets are: source address 0x00, destination address 0x04, remaining count 0x08, request type 0x0C, control/status 0x10. The count holds 24 bits and its upper bits read 0. The request type keeps the low 5 bits. Read data appears on `reg_rdata` one clock after `reg_addr` is presented.
- R2: After reset every register reads 0, and `m_req` and `irq` are low.
- R3: Control/status bits 10:8 select the unit size: code 0 is 4 bytes, 1 is 1 byte, 2 is 2 bytes, 3 is 16 bytes and 4 is 32 bytes. `m_bytes` shows the selected size. Unit data occupies the low bytes of the data buses.
- R4: Each unit is a read at the current source address, then a write at the current destination address whose low unit bytes equal the read data. `m_req`, `m_we` and `m_addr` hold steady until `m_ack`.
- R5: Control/status bit 23 makes the source address advance by the unit size after each unit. Bit 22 does the same for the destination address. When a bit is clear, that address stays fixed.
- R6: The count decrements by one per unit. When it reaches zero, the completion flag (bit 3) sets, the count reads 0 and no further requests are issued.
- R7: `irq` is high while the completion flag and the interrupt enable (bit 1) are both set. With bit 1 clear, completion raises no interrupt.
- R8: Flag bits 2, 3 and 4 are sticky. A write of 0 clears a flag and a write of 1 leaves it unchanged. Clearing bit 3 drops `irq` on the same clock edge. Bit 2 always reads 0.
- R9: A source or destination address that is not a multiple of the unit size, or a size code of 5 to 7, sets the error flag (bit 4). No request is issued, the count is unchanged, and neither completion nor `irq` occurs.
- R10: No request is issued unless control/status bit 0 and `glob_en` are both high and the count is non-zero. Enabling the channel with a zero count moves nothing and does not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_en | input | 1 | Controller-wide enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| m_req | output | 1 | Master request, held until acknowledged |
| m_we | output | 1 | 1 = write beat, 0 = read beat |
| m_addr | output | ADDR_W | Byte address of the beat |
| m_bytes | output | BYTES_W | Unit size in bytes |
| m_wdata | output | DATA_W | Write data |
| m_rdata | input | DATA_W | Read data, valid with m_ack on a read |
| m_ack | input | 1 | Acknowledge of the current beat |
| irq | output | 1 | Channel interrupt |

## Verification
A wrong count or a wrong step shows at the master port on the very next beat. The beat appears at an address other than the one expected from the start address and the number of units already done. At the end of the run, the source and destination registers read back a wrong final value. A completion flag held wrongly shows as an extra or missing beat, or as `irq` rising one unit early or late. A write beat carrying data that is not from the read just before it shows as a data mismatch at that beat. A wrong alignment decision shows within a few clocks, as either a beat that should never be issued or an error flag that never sets.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam logic [4:0] OFS_SRC = 5'h00;
  localparam logic [4:0] OFS_DST = 5'h04;
  localparam logic [4:0] OFS_CNT = 5'h08;
  localparam logic [4:0] OFS_REQ = 5'h0C;
  localparam logic [4:0] OFS_CSR = 5'h10;

  localparam int B_EN    = 0;
  localparam int B_IEN   = 1;
  localparam int B_HLT   = 2;
  localparam int B_DONE  = 3;
  localparam int B_ERR   = 4;
  localparam int B_SZ_LO = 8;
  localparam int B_DINC  = 22;
  localparam int B_SINC  = 23;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} fsm_t;
endpackage

// File: rtl/dma_unit_decode.sv
module dma_unit_decode #(
  parameter int BYTES_W = 6
) (
  input  logic [2:0]         code,
  output logic [BYTES_W-1:0] bytes,
  output logic               legal
);
  always_comb begin
    legal = 1'b1;
    case (code)
      3'd0:    bytes = BYTES_W'(4);
      3'd1:    bytes = BYTES_W'(1);
      3'd2:    bytes = BYTES_W'(2);
      3'd3:    bytes = BYTES_W'(16);
      3'd4:    bytes = BYTES_W'(32);
      default: begin
        bytes = BYTES_W'(1);
        legal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W  = 32,
  parameter int BYTES_W = 6
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BYTES_W-1:0] bytes,
  input  logic               inc,
  output logic [ADDR_W-1:0]  next,
  output logic               misaligned
);
  assign misaligned = |(addr[BYTES_W-1:0] & (bytes - BYTES_W'(1)));
  assign next       = inc ? addr + ADDR_W'(bytes) : addr;
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              bad,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic              m_ack,
  input  logic [DATA_W-1:0] m_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  output logic              unit_done,
  output logic              fault
);
  fsm_t state;

  assign unit_done = (state == ST_WRITE) && m_ack;
  assign fault     = (state == ST_IDLE) && go && bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      m_req   <= 1'b0;
      m_we    <= 1'b0;
      m_addr  <= '0;
      m_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go && !bad) begin
          state  <= ST_READ;
          m_req  <= 1'b1;
          m_we   <= 1'b0;
          m_addr <= src;
        end
        ST_READ: if (m_ack) begin
          state   <= ST_WRITE;
          m_we    <= 1'b1;
          m_addr  <= dst;
          m_wdata <= m_rdata;
        end
        ST_WRITE: if (m_ack) begin
          state <= ST_IDLE;
          m_req <= 1'b0;
          m_we  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: an unacknowledged beat keeps its request, direction and address
  assert_beat_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ack) |=> (m_req && $stable(m_we) && $stable(m_addr)));

  // R10: an idle engine without permission starts nothing
  assert_no_start_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !go) |=> !m_req);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_UNIT = 32,
  parameter int CNT_W    = 24,
  parameter int REQ_W    = 5,
  localparam int DATA_W  = 8 * MAX_UNIT,
  localparam int BYTES_W = $clog2(MAX_UNIT) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glob_en,
  input  logic               reg_we,
  input  logic [4:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               m_req,
  output logic               m_we,
  output logic [ADDR_W-1:0]  m_addr,
  output logic [BYTES_W-1:0] m_bytes,
  output logic [DATA_W-1:0]  m_wdata,
  input  logic [DATA_W-1:0]  m_rdata,
  input  logic               m_ack,
  output logic               irq
);
  logic [ADDR_W-1:0] addr_q [2];
  logic [ADDR_W-1:0] addr_nx [2];
  logic [1:0]        mis;
  logic [1:0]        inc_v;
  logic [CNT_W-1:0]  cnt_q;
  logic [REQ_W-1:0]  reqt_q;
  logic [2:0]        sz_q;
  logic              en_q, ien_q, sinc_q, dinc_q, done_q, err_q;
  logic              done_n, err_n, ien_n;
  logic              legal, go, bad, unit_done, fault, last_unit, csr_wr;
  logic [31:0]       csr_rd;

  dma_unit_decode #(.BYTES_W(BYTES_W)) u_dec (
    .code(sz_q), .bytes(m_bytes), .legal(legal));

  assign inc_v = {dinc_q, sinc_q};

  for (genvar g = 0; g < 2; g++) begin : g_step
    dma_addr_step #(.ADDR_W(ADDR_W), .BYTES_W(BYTES_W)) u_step (
      .addr(addr_q[g]), .bytes(m_bytes), .inc(inc_v[g]),
      .next(addr_nx[g]), .misaligned(mis[g]));
  end

  assign go        = glob_en && en_q && !done_q && !err_q && (cnt_q != '0);
  assign bad       = !legal || (|mis);
  assign last_unit = unit_done && (cnt_q == CNT_W'(1));
  assign csr_wr    = reg_we && (reg_addr == OFS_CSR);

  dma_chan_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .go(go), .bad(bad),
    .src(addr_q[0]), .dst(addr_q[1]),
    .m_ack(m_ack), .m_rdata(m_rdata),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .unit_done(unit_done), .fault(fault));

  // Sticky flags: software can only clear, hardware set wins a collision
  always_comb begin
    done_n = done_q;
    err_n  = err_q;
    ien_n  = ien_q;
    if (csr_wr) begin
      done_n = done_q & reg_wdata[B_DONE];
      err_n  = err_q & reg_wdata[B_ERR];
      ien_n  = reg_wdata[B_IEN];
    end
    if (last_unit) done_n = 1'b1;
    if (fault)     err_n  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q[0] <= '0;
      addr_q[1] <= '0;
      cnt_q     <= '0;
      reqt_q    <= '0;
      sz_q      <= '0;
      en_q      <= 1'b0;
      ien_q     <= 1'b0;
      sinc_q    <= 1'b0;
      dinc_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      irq       <= 1'b0;
    end else begin
      done_q <= done_n;
      err_q  <= err_n;
      ien_q  <= ien_n;
      irq    <= done_n && ien_n;
      if (unit_done) begin
        addr_q[0] <= addr_nx[0];
        addr_q[1] <= addr_nx[1];
        cnt_q     <= cnt_q - CNT_W'(1);
      end
      if (reg_we) begin
        case (reg_addr)
          OFS_SRC: addr_q[0] <= reg_wdata[ADDR_W-1:0];
          OFS_DST: addr_q[1] <= reg_wdata[ADDR_W-1:0];
          OFS_CNT: cnt_q     <= reg_wdata[CNT_W-1:0];
          OFS_REQ: reqt_q    <= reg_wdata[REQ_W-1:0];
          OFS_CSR: begin
            en_q   <= reg_wdata[B_EN];
            sinc_q <= reg_wdata[B_SINC];
            dinc_q <= reg_wdata[B_DINC];
            sz_q   <= reg_wdata[B_SZ_LO+2:B_SZ_LO];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    csr_rd                    = '0;
    csr_rd[B_EN]              = en_q;
    csr_rd[B_IEN]             = ien_q;
    csr_rd[B_HLT]             = 1'b0;
    csr_rd[B_DONE]            = done_q;
    csr_rd[B_ERR]             = err_q;
    csr_rd[B_SZ_LO+2:B_SZ_LO] = sz_q;
    csr_rd[B_DINC]            = dinc_q;
    csr_rd[B_SINC]            = sinc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        OFS_SRC: reg_rdata <= 32'(addr_q[0]);
        OFS_DST: reg_rdata <= 32'(addr_q[1]);
        OFS_CNT: reg_rdata <= 32'(cnt_q);
        OFS_REQ: reg_rdata <= 32'(reqt_q);
        OFS_CSR: reg_rdata <= csr_rd;
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R6: each finished unit takes exactly one off the count
  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    (unit_done && !(reg_we && reg_addr == OFS_CNT)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R9: with the error flag up, the master port stays quiet
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !m_req);

  // R9: every issued beat is aligned to the unit size
  assert_beat_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    m_req |-> ((m_addr[BYTES_W-1:0] & (m_bytes - BYTES_W'(1))) == '0));

  // R8: a zero written to the completion flag removes the interrupt
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && !reg_wdata[B_DONE] && !last_unit) |=> !irq);

  // R7: the interrupt line never stands without its flag
  assert_irq_flag_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> done_q);
endmodule

// File: tb/test_dma_chan_ctrl.sv
module test_dma_chan_ctrl;
  localparam int AW = 32;
  localparam int DW = 256;
  localparam int BW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          glob_en = 1'b1;
  logic          reg_we = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          m_req, m_we, irq;
  logic [AW-1:0] m_addr;
  logic [BW-1:0] m_bytes;
  logic [DW-1:0] m_wdata;
  logic [DW-1:0] m_rdata;
  logic          m_ack;

  dma_chan_ctrl i_dma_chan_ctrl (
    .clk(clk), .rst(rst), .glob_en(glob_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_bytes(m_bytes), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_ack(m_ack), .irq(irq));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, r_chk = 0, r_fail = 0;
  int n_rd = 0, n_wr = 0;
  int rd0 = 0, wr0 = 0;
  logic [31:0] cfg_src = 0, cfg_dst = 0;
  int cfg_bytes = 4;
  bit cfg_sinc = 0, cfg_dinc = 0;
  bit finished = 0;

  function automatic int unit_bytes(input int code);
    case (code)
      0: return 4;
      1: return 1;
      2: return 2;
      3: return 16;
      4: return 32;
      default: return 1;
    endcase
  endfunction

  function automatic logic [DW-1:0] pattern(input logic [31:0] a);
    return {8{a * 32'h9E37_79B1 + 32'h0F1E_2D3C}};
  endfunction

  function automatic logic [DW-1:0] lane_mask(input int b);
    return (DW'(1) << (8 * b)) - DW'(1);
  endfunction

  function automatic logic [31:0] csr_word(input int code, input bit si, input bit di,
                                           input bit ien, input bit en);
    return (32'(si) << 23) | (32'(di) << 22) | (32'(code) << 8) | (32'(ien) << 1) | 32'(en);
  endfunction

  // Memory responder: acks after 0..2 wait cycles, always one idle cycle after an ack
  initial begin
    logic [DW-1:0] last_rd;
    logic [31:0]   exp_a;
    int dly, dcnt;
    m_ack = 1'b0; m_rdata = '0; last_rd = '0; dly = 0; dcnt = 0;
    forever begin
      @(negedge clk);
      if (m_ack) m_ack = 1'b0;
      else if (m_req && !rst) begin
        if (dcnt < dly) dcnt++;
        else begin
          dcnt = 0;
          dly  = (dly + 1) % 3;
          m_ack = 1'b1;
          r_chk++;
          if (int'(m_bytes) != cfg_bytes) begin
            r_fail++;
            $display("FAIL R3 unit size act=%0d exp=%0d", m_bytes, cfg_bytes);
          end
          if (!m_we) begin
            exp_a = cfg_src + (cfg_sinc ? 32'(cfg_bytes * (n_rd - rd0)) : 32'd0);
            r_chk++;
            if (m_addr !== exp_a) begin
              r_fail++;
              $display("FAIL R5 read address act=%h exp=%h", m_addr, exp_a);
            end
            m_rdata = pattern(m_addr);
            last_rd = m_rdata;
            n_rd++;
          end else begin
            exp_a = cfg_dst + (cfg_dinc ? 32'(cfg_bytes * (n_wr - wr0)) : 32'd0);
            r_chk++;
            if (m_addr !== exp_a) begin
              r_fail++;
              $display("FAIL R5 write address act=%h exp=%h", m_addr, exp_a);
            end
            r_chk++;
            if (((m_wdata ^ last_rd) & lane_mask(cfg_bytes)) != '0) begin
              r_fail++;
              $display("FAIL R4 write data act=%h exp=%h", m_wdata & lane_mask(cfg_bytes),
                       last_rd & lane_mask(cfg_bytes));
            end
            n_wr++;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(output bit seen);
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
  endtask

  task automatic setup(input int code, input bit si, input bit di,
                       input logic [31:0] s, input logic [31:0] d, input int n);
    cfg_bytes = unit_bytes(code); cfg_sinc = si; cfg_dinc = di;
    cfg_src = s; cfg_dst = d; rd0 = n_rd; wr0 = n_wr;
    wr(5'h00, s);
    wr(5'h04, d);
    wr(5'h08, 32'(n));
    wr(5'h10, csr_word(code, si, di, 1'b1, 1'b1));
  endtask

  task automatic run_xfer(input int code, input bit si, input bit di, input int n);
    logic [31:0] v, s, d;
    bit seen;
    int b;
    b = unit_bytes(code);
    s = 32'h1000 + 32'(code) * 32'h100;
    d = 32'h8000 + 32'(code) * 32'h400;
    setup(code, si, di, s, d, n);
    wait_irq(seen);
    check(seen, "R7 irq on completion", 32'(seen), 32'd1);
    rd(5'h10, v);
    check(v[3] == 1'b1 && v[2] == 1'b0, "R6 completion flag", v, v | 32'h8);
    rd(5'h08, v);
    check(v == 0, "R6 count reads zero", v, 0);
    rd(5'h00, v);
    check(v == s + (si ? 32'(n * b) : 0), "R5 final source", v, s + (si ? 32'(n * b) : 0));
    rd(5'h04, v);
    check(v == d + (di ? 32'(n * b) : 0), "R5 final destination", v, d + (di ? 32'(n * b) : 0));
    idle(6);
    check(n_rd - rd0 == n && n_wr - wr0 == n, "R4 beats per unit",
          32'(n_rd - rd0), 32'(n));
    wr(5'h10, 32'd0);
    check(irq == 1'b0, "R8 irq dropped by clear", 32'(irq), 0);
    rd(5'h10, v);
    check(v == 0, "R8 status cleared", v, 0);
  endtask

  initial begin
    logic [31:0] v;
    bit seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    check(m_req == 1'b0 && irq == 1'b0, "R2 outputs after reset", {30'd0, m_req, irq}, 0);
    for (int k = 0; k < 5; k++) begin
      rd(5'(4 * k), v);
      check(v == 0, "R2 register after reset", v, 0);
    end

    // R1 field widths and readback
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v);
    check(v == 32'h00FF_FFFF, "R1 count width", v, 32'h00FF_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, v);
    check(v == 32'h0000_001F, "R1 request type width", v, 32'h1F);
    wr(5'h10, 32'hFFFF_FFFE);
    rd(5'h10, v);
    check(v == 32'h00C0_0702, "R1 R8 control readback, flags stay clear", v, 32'h00C0_0702);
    check(m_req == 1'b0, "R10 disabled channel idle", 32'(m_req), 0);
    wr(5'h10, 32'd0);

    // R3 R4 R5 R6 R7: sweep every size code and stepping combination
    for (int c = 0; c < 5; c++)
      for (int m = 0; m < 4; m++)
        run_xfer(c, m[0], m[1], 1 + (c + m) % 3);

    // R8 sticky flags: writing ones does not set or clear
    setup(1, 1'b1, 1'b1, 32'h2000, 32'h3000, 2);
    wait_irq(seen);
    wr(5'h10, csr_word(1, 1'b1, 1'b1, 1'b1, 1'b1) | 32'h1C);
    rd(5'h10, v);
    check(v[4:2] == 3'b010, "R8 flag write of ones", {29'd0, v[4:2]}, 32'b010);
    check(irq == 1'b1, "R8 irq kept", 32'(irq), 1);
    wr(5'h10, 32'd0);

    // R7 completion with interrupt disabled
    cfg_bytes = 4; cfg_sinc = 1; cfg_dinc = 1; cfg_src = 32'h4000; cfg_dst = 32'h5000;
    rd0 = n_rd; wr0 = n_wr;
    wr(5'h00, 32'h4000); wr(5'h04, 32'h5000); wr(5'h08, 32'd3);
    wr(5'h10, csr_word(0, 1'b1, 1'b1, 1'b0, 1'b1));
    idle(120);
    rd(5'h10, v);
    check(v[3] == 1'b1, "R7 flag without interrupt enable", v, v | 32'h8);
    check(irq == 1'b0, "R7 no irq when disabled", 32'(irq), 0);
    wr(5'h10, 32'd0);

    // R9 misaligned source, misaligned destination, undefined size code
    for (int t = 0; t < 3; t++) begin
      int code;
      logic [31:0] s, d;
      code = (t == 0) ? 2 : (t == 1) ? 3 : 5;
      s = (t == 0) ? 32'h1001 : 32'h1000;
      d = (t == 1) ? 32'h8008 : 32'h8000;
      cfg_bytes = unit_bytes(code); rd0 = n_rd; wr0 = n_wr;
      wr(5'h00, s); wr(5'h04, d); wr(5'h08, 32'd3);
      wr(5'h10, csr_word(code, 1'b1, 1'b1, 1'b1, 1'b1));
      idle(20);
      rd(5'h10, v);
      check(v[4] == 1'b1 && v[3] == 1'b0, "R9 error flag set, no completion", v,
            (v | 32'h10) & ~32'h8);
      rd(5'h08, v);
      check(v == 3, "R9 count unchanged", v, 3);
      check(n_rd == rd0 && irq == 1'b0, "R9 no beats, no irq", 32'(n_rd - rd0), 0);
      wr(5'h10, 32'd0);
      rd(5'h10, v);
      check(v[4] == 1'b0, "R8 error flag cleared", v, 0);
    end

    // R10 controller enable gates requests
    glob_en = 1'b0;
    setup(0, 1'b1, 1'b0, 32'h6000, 32'h7000, 2);
    idle(30);
    check(n_rd == rd0, "R10 no beats with glob_en low", 32'(n_rd - rd0), 0);
    rd(5'h08, v);
    check(v == 2, "R10 count held", v, 2);
    glob_en = 1'b1;
    wait_irq(seen);
    check(seen && n_wr - wr0 == 2, "R10 transfer after glob_en", 32'(n_wr - wr0), 2);
    wr(5'h10, 32'd0);

    // R10 zero count
    rd0 = n_rd;
    wr(5'h08, 32'd0);
    wr(5'h10, csr_word(0, 1'b0, 1'b0, 1'b1, 1'b1));
    idle(20);
    rd(5'h10, v);
    check(n_rd == rd0 && v[3] == 1'b0, "R10 zero count moves nothing", v, v & ~32'h8);
    wr(5'h10, 32'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + r_chk,
             n_fail + r_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + r_chk + 1,
               n_fail + r_fail + 1);
      $finish;
    end
  end
endmodule